// File: doc/BRIEF.md
# DRAM Mode-Register Initialization Sequencer

This block drives the command stream that brings an external DRAM out of power-up and into a programmed state. Once the PHY reports that power-up is complete and a start pulse arrives, the sequencer walks a fixed list of steps. The list is chosen by a memory-type code, which is captured when the start is accepted. For each step it raises a start flag on a small command port. The command carries an opcode, a rank mask, an address (a bank address for DDR3, a mode-register number for LPDDR2/3) and an operand. The flag stays high until the memory controller acknowledges the command.

DDR3 and the LPDDR family use different orders. DDR3 gets a deselect, a settle wait, precharge-all, and four mode-register writes in the order MR2, MR3, MR1, MR0. The MR0 write has DLL reset forced on, and a long ZQ calibration closes the list. LPDDR2/3 gets a reset write with its recovery wait, then two ZQ-init writes, each followed by a wait. After that come MR1, MR2 and MR3, and for LPDDR3 only, MR11. All waits are counted in microseconds using a cycles-per-microsecond parameter. The mode-register values are taken directly from the inputs, which must stay stable while the sequence runs. A sticky done output marks completion.

Top module: `dram_mr_init_seq`

## Requirements
- R1: A start is accepted only in a cycle where `start_i` and `pwrup_done_i` are both high and the sequencer is idle. A start pulse without power-up-done, or one that arrives while a sequence is running, has no effect.
- R2: With type code 2'b00 (DDR3) the commands are issued in this order, with opcodes DESELECT=0, PREA=1, MRS=2, ZQCL=3: DESELECT, a 1 µs wait, PREA, then MRS to bank 2 carrying `mr2_i`, bank 3 carrying `mr3_i`, bank 1 carrying `mr1_i` and bank 0 carrying `mr0_i`, and finally ZQCL. For non-MRS commands the address and operand are zero.
- R3: The DDR3 MRS to bank 0 carries `mr0_i` with bit 8 (DLL reset) forced to 1.
- R4: With type codes 2'b01, 2'b10 or 2'b11 (LPDDR) the sequence opens with these writes: MRS to address 63 with operand 0, then a 10 µs wait; MRS to address 10 with operand 0xFF, then 1 µs; the same write again, then 1 µs.
- R5: The LPDDR path continues with MRS to addresses 1, 2 and 3, carrying bits [7:0] of `mr1_i`, `mr2_i` and `mr3_i`, zero-extended. Type codes 2'b10 and 2'b11 (LPDDR3) add a final MRS to address 11 carrying `mr11_i`. Code 2'b01 (LPDDR2) ends after address 3.
- R6: Every command carries rank mask 2'b11.
- R7: `cmd_start_o` stays high with its opcode and address unchanged until `cmd_done_i` is sampled high. It is low in the following cycle, so the flag is low for at least one cycle between commands.
- R8: After a step with a W µs wait is acknowledged, the next command flag rises W×CYCLES_PER_US+1 cycles after the acknowledging edge. For a step without a wait, it rises 1 cycle after that edge.
- R9: `done_o` rises 2 clock edges after the last command is acknowledged. It stays high until the next accepted start, which clears it, and it is low out of reset.
- R10: The memory type is captured at the accepted start. Changes on `mem_type_i` during a running sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run the sequence |
| pwrup_done_i | input | 1 | PHY power-up complete; qualifies start |
| mem_type_i | input | 2 | 00 DDR3, 01 LPDDR2, 10/11 LPDDR3 |
| mr0_i | input | MR_W | MR0 value (DDR3 only) |
| mr1_i | input | MR_W | MR1 value |
| mr2_i | input | MR_W | MR2 value |
| mr3_i | input | MR_W | MR3 value |
| mr11_i | input | 8 | MR11 operand (LPDDR3 only) |
| cmd_start_o | output | 1 | Command start flag, held until acknowledged |
| cmd_op_o | output | 3 | Command opcode |
| cmd_rank_o | output | 2 | Rank mask |
| cmd_addr_o | output | 8 | Bank address or mode-register number |
| cmd_data_o | output | MR_W | Command operand |
| cmd_done_i | input | 1 | Controller acknowledge of the current command |
| done_o | output | 1 | Sequence complete (sticky) |

## Verification
A corrupted step index or a wrongly captured memory type shows up at the very next command flag, as a wrong opcode, address or operand. A miscounting timer moves the rise of the next flag away from its exact cycle, which shows up one step after any waited command. A stuck or skipped end-of-list decision shows as `done_o` failing to rise two edges after the last acknowledge, or as an extra command flag.

// File: rtl/dram_seq_pkg.sv
// Package: shared encodings for the DRAM mode-register init sequencer.
// Assumes: a 3-bit opcode field and a 2-bit memory type code on the ports.
package dram_seq_pkg;

    typedef enum logic [1:0] {
        MT_DDR3     = 2'b00,
        MT_LPDDR2   = 2'b01,
        MT_LPDDR3   = 2'b10,
        MT_LPDDR3_B = 2'b11
    } mem_type_e;

    typedef enum logic [2:0] {
        OP_DESELECT = 3'd0,
        OP_PREA     = 3'd1,
        OP_MRS      = 3'd2,
        OP_ZQCL     = 3'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_NEXT  = 2'd3
    } seq_state_e;

    localparam int STEP_W     = 3;
    localparam int US_W       = 4;
    localparam int ADDR_W     = 8;
    localparam logic [1:0] RANK_ALL = 2'b11;

    localparam logic [ADDR_W-1:0] MA_RESET = 8'd63;
    localparam logic [ADDR_W-1:0] MA_ZQ    = 8'd10;
    localparam logic [ADDR_W-1:0] MA_MR11  = 8'd11;
    localparam logic [7:0]        ZQ_INIT_OP = 8'hFF;

endpackage

// File: rtl/seq_step_table.sv
// Module: seq_step_table
// Combinational description of each step of the init list. The list is
// picked by the captured memory type. Each step gives an opcode, an
// address, an operand, a post-step wait in microseconds, and a last-step flag.
// Assumes: MR_W >= 8 and DLL_BIT < MR_W.
module seq_step_table
    import dram_seq_pkg::*;
#(
    parameter int MR_W            = 16,
    parameter int DLL_BIT         = 8,
    parameter int DDR3_SETTLE_US  = 1,
    parameter int LP_RESET_US     = 10,
    parameter int LP_ZQ_US        = 1
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              is_ddr3_i,
    input  logic              has_mr11_i,
    input  logic [MR_W-1:0]   mr0_i,
    input  logic [MR_W-1:0]   mr1_i,
    input  logic [MR_W-1:0]   mr2_i,
    input  logic [MR_W-1:0]   mr3_i,
    input  logic [7:0]        mr11_i,
    output logic [2:0]        op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [MR_W-1:0]   data_o,
    output logic [US_W-1:0]   wait_us_o,
    output logic              last_o
);

    localparam int PAD_W = MR_W - 8;
    localparam logic [MR_W-1:0] DLL_MASK = MR_W'(1) << DLL_BIT;

    // Zero-extend an 8-bit LPDDR operand to the operand width.
    function automatic logic [MR_W-1:0] lp_op(input logic [7:0] v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    // Decode the current step into a command and its trailing wait.
    always_comb begin
        op_o      = OP_DESELECT;
        addr_o    = '0;
        data_o    = '0;
        wait_us_o = '0;
        last_o    = 1'b0;
        if (is_ddr3_i) begin
            case (step_i)
                3'd0: begin
                    op_o      = OP_DESELECT;
                    wait_us_o = US_W'(DDR3_SETTLE_US);
                end
                3'd1: op_o = OP_PREA;
                3'd2: begin op_o = OP_MRS; addr_o = 8'd2; data_o = mr2_i; end
                3'd3: begin op_o = OP_MRS; addr_o = 8'd3; data_o = mr3_i; end
                3'd4: begin op_o = OP_MRS; addr_o = 8'd1; data_o = mr1_i; end
                3'd5: begin
                    op_o   = OP_MRS;
                    addr_o = 8'd0;
                    data_o = mr0_i | DLL_MASK;
                end
                3'd6: begin op_o = OP_ZQCL; last_o = 1'b1; end
                default: last_o = 1'b1;
            endcase
        end else begin
            case (step_i)
                3'd0: begin
                    op_o      = OP_MRS;
                    addr_o    = MA_RESET;
                    wait_us_o = US_W'(LP_RESET_US);
                end
                3'd1, 3'd2: begin
                    op_o      = OP_MRS;
                    addr_o    = MA_ZQ;
                    data_o    = lp_op(ZQ_INIT_OP);
                    wait_us_o = US_W'(LP_ZQ_US);
                end
                3'd3: begin op_o = OP_MRS; addr_o = 8'd1; data_o = lp_op(mr1_i[7:0]); end
                3'd4: begin op_o = OP_MRS; addr_o = 8'd2; data_o = lp_op(mr2_i[7:0]); end
                3'd5: begin
                    op_o   = OP_MRS;
                    addr_o = 8'd3;
                    data_o = lp_op(mr3_i[7:0]);
                    last_o = !has_mr11_i;
                end
                3'd6: begin
                    op_o   = OP_MRS;
                    addr_o = MA_MR11;
                    data_o = lp_op(mr11_i);
                    last_o = 1'b1;
                end
                default: last_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/seq_us_timer.sv
// Module: seq_us_timer
// Counts a wait of us_i microseconds, each CYCLES_PER_US clocks long.
// Asserts expire_o in the final cycle of the wait.
// Assumes: load_i arrives only while idle, and us_i is non-zero on load.
module seq_us_timer #(
    parameter int CYCLES_PER_US = 400,
    parameter int US_W          = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] us_i,
    output logic            expire_o
);

    localparam int CYC_W = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
    localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(CYCLES_PER_US - 1);

    logic [CYC_W-1:0] cyc_q;
    logic [US_W-1:0]  us_left_q;

    assign expire_o = (us_left_q == US_W'(1)) && (cyc_q == '0);

    // Load the wait, then step the sub-microsecond and microsecond counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            us_left_q <= '0;
        end else if (load_i) begin
            cyc_q     <= CYC_TOP;
            us_left_q <= us_i;
        end else if (us_left_q != '0) begin
            if (cyc_q == '0) begin
                cyc_q     <= CYC_TOP;
                us_left_q <= us_left_q - US_W'(1);
            end else begin
                cyc_q <= cyc_q - CYC_W'(1);
            end
        end
    end

endmodule

// File: rtl/dram_mr_init_seq.sv
// Module: dram_mr_init_seq (top)
// Runs the DRAM power-up command list once per qualified start. The
// memory type is captured at start. Each command is held on the port
// until acknowledged, and the flag drops for at least one cycle between
// commands. Microsecond waits come from seq_us_timer.
// Assumes: mrX_i stay stable while the sequence runs.
module dram_mr_init_seq
    import dram_seq_pkg::*;
#(
    parameter int CYCLES_PER_US = 400,
    parameter int MR_W          = 16,
    parameter int DLL_BIT       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            pwrup_done_i,
    input  logic [1:0]      mem_type_i,
    input  logic [MR_W-1:0] mr0_i,
    input  logic [MR_W-1:0] mr1_i,
    input  logic [MR_W-1:0] mr2_i,
    input  logic [MR_W-1:0] mr3_i,
    input  logic [7:0]      mr11_i,
    output logic            cmd_start_o,
    output logic [2:0]      cmd_op_o,
    output logic [1:0]      cmd_rank_o,
    output logic [7:0]      cmd_addr_o,
    output logic [MR_W-1:0] cmd_data_o,
    input  logic            cmd_done_i,
    output logic            done_o
);

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [1:0]        type_q;
    logic              done_q;

    logic              ddr3_sel;
    logic              mr11_sel;
    logic              seq_idle;
    logic [US_W-1:0]   step_wait_us;
    logic              step_last;
    logic              timer_load;
    logic              timer_expire;
    logic              accept;

    assign ddr3_sel = (type_q == MT_DDR3);
    assign mr11_sel = type_q[1];
    assign seq_idle = (state_q == ST_IDLE);
    assign accept   = seq_idle && start_i && pwrup_done_i;

    seq_step_table #(
        .MR_W    (MR_W),
        .DLL_BIT (DLL_BIT)
    ) u_table (
        .step_i     (step_q),
        .is_ddr3_i  (ddr3_sel),
        .has_mr11_i (mr11_sel),
        .mr0_i      (mr0_i),
        .mr1_i      (mr1_i),
        .mr2_i      (mr2_i),
        .mr3_i      (mr3_i),
        .mr11_i     (mr11_i),
        .op_o       (cmd_op_o),
        .addr_o     (cmd_addr_o),
        .data_o     (cmd_data_o),
        .wait_us_o  (step_wait_us),
        .last_o     (step_last)
    );

    assign timer_load = (state_q == ST_ISSUE) && cmd_done_i && (step_wait_us != '0);

    seq_us_timer #(
        .CYCLES_PER_US (CYCLES_PER_US),
        .US_W          (US_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (timer_load),
        .us_i     (step_wait_us),
        .expire_o (timer_expire)
    );

    assign cmd_start_o = (state_q == ST_ISSUE);
    assign cmd_rank_o  = RANK_ALL;
    assign done_o      = done_q;

    // Step through issue, wait and advance phases until the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            type_q  <= MT_DDR3;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_ISSUE;
                        step_q  <= '0;
                        type_q  <= mem_type_i;
                        done_q  <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_done_i) begin
                        state_q <= (step_wait_us != '0) ? ST_WAIT : ST_NEXT;
                    end
                end
                ST_WAIT: begin
                    if (timer_expire) begin
                        state_q <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (step_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q  <= step_q + STEP_W'(1);
                        state_q <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dram_mr_init_seq_chk.sv
// Module: dram_mr_init_seq_chk
// Property checker for dram_mr_init_seq, attached by bind below.
module dram_mr_init_seq_chk
    import dram_seq_pkg::*;
#(
    parameter int MR_W    = 16,
    parameter int DLL_BIT = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            pwrup_done_i,
    input logic            idle_i,
    input logic            ddr3_i,
    input logic            cmd_start_o,
    input logic [2:0]      cmd_op_o,
    input logic [1:0]      cmd_rank_o,
    input logic [7:0]      cmd_addr_o,
    input logic [MR_W-1:0] cmd_data_o,
    input logic            cmd_done_i,
    input logic            done_o
);

    a_r1_no_launch_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i && !(start_i && pwrup_done_i) |=> !cmd_start_o);

    a_r6_both_ranks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |-> cmd_rank_o == 2'b11);

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o && !cmd_done_i |=> cmd_start_o && $stable(cmd_op_o) && $stable(cmd_addr_o));

    a_r7_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o && cmd_done_i |=> !cmd_start_o);

    a_r3_dll_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o && ddr3_i && cmd_op_o == OP_MRS && cmd_addr_o == 8'd0
        |-> cmd_data_o[DLL_BIT]);

    a_r9_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(cmd_done_i, 2));

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_start_o);

endmodule

bind dram_mr_init_seq dram_mr_init_seq_chk #(
    .MR_W    (MR_W),
    .DLL_BIT (DLL_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pwrup_done_i (pwrup_done_i),
    .idle_i       (seq_idle),
    .ddr3_i       (ddr3_sel),
    .cmd_start_o  (cmd_start_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_rank_o   (cmd_rank_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_data_o   (cmd_data_o),
    .cmd_done_i   (cmd_done_i),
    .done_o       (done_o)
);

// File: tb/dram_mr_init_seq_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every memory type code against three acknowledge delays.
// The expected command lists and wait timings are built from the requirements.
module dram_mr_init_seq_bench;

    localparam int CPU  = 4;
    localparam int MR_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            pwrup_done_i = 1'b0;
    logic [1:0]      mem_type_i = 2'b00;
    logic [MR_W-1:0] mr0_i = '0, mr1_i = '0, mr2_i = '0, mr3_i = '0;
    logic [7:0]      mr11_i = '0;
    logic            cmd_start_o;
    logic [2:0]      cmd_op_o;
    logic [1:0]      cmd_rank_o;
    logic [7:0]      cmd_addr_o;
    logic [MR_W-1:0] cmd_data_o;
    logic            cmd_done_i = 1'b0;
    logic            done_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [2:0]  e_op   [8];
    logic [7:0]  e_addr [8];
    logic [15:0] e_data [8];
    int          e_wait [8];
    int          e_n;

    always #2.5 clk = ~clk;

    dram_mr_init_seq #(.CYCLES_PER_US(CPU), .MR_W(MR_W), .DLL_BIT(8)) u_dram_mr_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwrup_done_i(pwrup_done_i),
        .mem_type_i(mem_type_i), .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i),
        .mr3_i(mr3_i), .mr11_i(mr11_i), .cmd_start_o(cmd_start_o), .cmd_op_o(cmd_op_o),
        .cmd_rank_o(cmd_rank_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
        .cmd_done_i(cmd_done_i), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int k, input logic [2:0] op, input logic [7:0] a,
                       input logic [15:0] d, input int w);
        e_op[k] = op; e_addr[k] = a; e_data[k] = d; e_wait[k] = w;
    endtask

    // Expected list per R2/R3 (DDR3) or R4/R5 (LPDDR).
    task automatic build(input logic [1:0] mt);
        if (mt == 2'b00) begin
            put(0, 3'd0, 8'd0, 16'h0, 1);
            put(1, 3'd1, 8'd0, 16'h0, 0);
            put(2, 3'd2, 8'd2, mr2_i, 0);
            put(3, 3'd2, 8'd3, mr3_i, 0);
            put(4, 3'd2, 8'd1, mr1_i, 0);
            put(5, 3'd2, 8'd0, mr0_i | 16'h0100, 0);
            put(6, 3'd3, 8'd0, 16'h0, 0);
            e_n = 7;
        end else begin
            put(0, 3'd2, 8'd63, 16'h0, 10);
            put(1, 3'd2, 8'd10, 16'h00FF, 1);
            put(2, 3'd2, 8'd10, 16'h00FF, 1);
            put(3, 3'd2, 8'd1, {8'h0, mr1_i[7:0]}, 0);
            put(4, 3'd2, 8'd2, {8'h0, mr2_i[7:0]}, 0);
            put(5, 3'd2, 8'd3, {8'h0, mr3_i[7:0]}, 0);
            put(6, 3'd2, 8'd11, {8'h0, mr11_i}, 0);
            e_n = mt[1] ? 7 : 6;
        end
    endtask

    task automatic run_seq(input logic [1:0] mt, input int dly, input bit perturb);
        int cnt;
        int exp_cnt;
        @(negedge clk);
        mem_type_i = mt; pwrup_done_i = 1'b1; start_i = 1'b1;
        build(mt);
        @(negedge clk);
        start_i = 1'b0;
        if (perturb) mem_type_i = ~mt;
        chk(done_o == 1'b0, "R9 done cleared by start", done_o, 0);
        exp_cnt = 0;
        for (int k = 0; k < e_n; k++) begin
            cnt = 0;
            while (!cmd_start_o && cnt < 200) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == exp_cnt, "R8 flag rise timing", cnt, exp_cnt);
            chk(cmd_op_o == e_op[k], "R2/R4/R5 opcode", cmd_op_o, e_op[k]);
            chk(cmd_addr_o == e_addr[k], "R2/R4/R5 address", cmd_addr_o, e_addr[k]);
            chk(cmd_data_o == e_data[k], "R3/R5 operand", cmd_data_o, e_data[k]);
            chk(cmd_rank_o == 2'b11, "R6 rank mask", cmd_rank_o, 3);
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                if (perturb && d == 0) start_i = 1'b1;
                else start_i = 1'b0;
            end
            start_i = 1'b0;
            chk(cmd_start_o && cmd_op_o == e_op[k] && cmd_addr_o == e_addr[k],
                "R7 held until ack", {cmd_start_o, cmd_op_o, cmd_addr_o}, {1'b1, e_op[k], e_addr[k]});
            cmd_done_i = 1'b1;
            @(negedge clk);
            cmd_done_i = 1'b0;
            chk(cmd_start_o == 1'b0, "R7 flag drops after ack", cmd_start_o, 0);
            exp_cnt = e_wait[k] * CPU + 1;
        end
        @(negedge clk);
        chk(done_o == 1'b1, "R9 done after last ack", done_o, 1);
        chk(cmd_start_o == 1'b0, "R5 no command past list end", cmd_start_o, 0);
        repeat (3) @(negedge clk);
        chk(done_o == 1'b1 && !cmd_start_o, "R9 done sticky", {done_o, cmd_start_o}, 2'b10);
        mem_type_i = mt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_start_o == 1'b0, "R9 reset flag low", cmd_start_o, 0);
        chk(done_o == 1'b0, "R9 reset done low", done_o, 0);

        // R1: start without power-up-done is ignored
        start_i = 1'b1; pwrup_done_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk(cmd_start_o == 1'b0 && done_o == 1'b0, "R1 unqualified start ignored",
                {cmd_start_o, done_o}, 0);
        end

        for (int mt = 0; mt < 4; mt++) begin
            for (int dly = 0; dly < 3; dly++) begin
                mr0_i  = 16'(((mt * 3 + dly) * 16'h1357) & 16'hFEFF);
                mr1_i  = 16'(16'h2000 + mt * 16'h0111 + dly * 16'h0023);
                mr2_i  = 16'(16'h4008 + mt * 16'h0205 + dly * 16'h0041);
                mr3_i  = 16'(16'h6001 + mt * 16'h0013 + dly * 16'h0107);
                mr11_i = 8'(8'h30 + mt * 7 + dly * 3);
                // R10: dly==1 runs change mem_type_i and retry start mid-run (R1)
                run_seq(2'(mt), dly, dly == 1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule